// File: doc/BRIEF.md
# SPI Diagnostic Status Word Generator

This block builds the 16-bit diagnostic status word that a serial peripheral port returns for an eight-channel load switch. It also checks every serial frame for a legal length. The SPI pins are sampled by the system clock through two-stage synchronizers. The word is loaded into a shift register when chip select falls and leaves MSB first on `miso`. Bits clocked in on `mosi` follow the word out after 16 shifts, so several devices can be chained on one select.

Undervoltage events and per-channel overload or overtemperature events set sticky flags. A flag clears only when a correctly framed frame has carried it out to the host. The operating mode, the open-load-at-on flag and the open-load-in-off summary are sampled live when a frame starts. A frame is legal when it holds 16 + 8·n falling SCLK edges. The outcome is reported in the next word. The very first frame after reset returns a fixed reply in place of the diagnostic word.

Top module: `diag_status_spi`

## Requirements
- R1: After reset, when mode is idle (11) and no event has occurred, the second frame (following a legal first frame) returns 16'h5800.
- R2: Word layout: bit 15 = 0, bit 14 = undervoltage flag, bit 13 = 0, bits 12:11 = mode (01 limp home, 10 active, 11 idle, 00 reserved), bit 10 = length-error flag, bit 9 = open-load-at-on input, bit 8 = open-load-in-off summary, bits 7:0 = per-channel fault flags (bit i = channel i).
- R3: The length-error flag reports the previous frame. It is 0 when that frame had at least 16 falling SCLK edges and the number of edges beyond 16 is a multiple of 8; otherwise it is 1. It resets to 1.
- R4: The first frame after reset returns 16'h0400 (length-error bit set, all other bits 0). Every later frame returns the diagnostic word.
- R5: The undervoltage flag resets to 1. A one-cycle `uv_evt` pulse sets it. It clears only at the end of a legal frame that returned the diagnostic word showing it as 1.
- R6: A one-cycle pulse on `chan_fault[i]` sets fault flag i. The flag follows the same clear rule as R5.
- R7: Bit 8 is the OR, over the channels with `chan_on[i]`=0 and `ol_src_en[i]`=1, of `ol_cmp[i]`. Channels that are on or not enabled have no effect on it.
- R8: Mode and the open-load-at-on bit are taken from the inputs at the start of the frame.
- R9: An event that arrives in the same cycle as the clear leaves its flag set.
- R10: A flag that read 0 in the returned word, and is set by an event during that frame, is not cleared at its end.
- R11: The word leaves MSB first and shifts one place per falling SCLK edge. After 16 shifts, `miso` returns the bits received on `mosi` in the order they arrived.
- R12: `miso_oe` is 0 while chip select is high (including after reset) and 1 during a frame.
- R13: A frame of illegal length clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low, asynchronous |
| sck | input | 1 | SPI serial clock (mode 1), asynchronous |
| mosi | input | 1 | SPI data in, asynchronous |
| uv_evt | input | 1 | Undervoltage event pulse |
| mode_in | input | 2 | Operating mode code |
| chan_fault | input | 8 | Per-channel overload/overtemperature pulses |
| ol_cmp | input | 8 | Per-channel open-load-in-off comparator result |
| chan_on | input | 8 | Per-channel on state |
| ol_src_en | input | 8 | Per-channel open-load current enable |
| olon_in | input | 1 | Open-load-at-on flag |
| miso | output | 1 | SPI data out |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |

## Verification
The assertions assume two things about the inputs. First, `uv_evt` and `chan_fault` are single-cycle pulses synchronous to `clk`. Second, the SPI master holds each SCLK level and each `mosi` bit for several system-clock cycles, longer than the synchronizer delay, so that every edge is seen exactly once. The stimulus keeps within this: each SCLK phase lasts six clock cycles, `mosi` changes only with the rising SCLK edge, and chip select never moves together with SCLK. Events are driven on the falling clock edge for one cycle. The clear-cycle collision is placed by counting the synchronizer stages from the chip-select release.

// File: rtl/diag_status_pkg.sv
package diag_status_pkg;

    localparam int NCH         = 8;
    localparam int WORD_W      = 16;
    localparam int MIN_BITS    = 16;
    // Frame length granularity beyond MIN_BITS; must be a power of two.
    localparam int STEP_BITS   = 8;
    localparam int STEP_W      = $clog2(STEP_BITS);
    localparam int MIN_W       = $clog2(MIN_BITS + 1);
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MODE_RSVD   = 2'b00,
        MODE_LIMP   = 2'b01,
        MODE_ACTIVE = 2'b10,
        MODE_IDLE   = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic             zero_hi;
        logic             uv;
        logic             zero_mid;
        op_mode_e         mode;
        logic             len_err;
        logic             olon;
        logic             oloff;
        logic [NCH-1:0]   fault;
    } diag_word_t;

    // Reply of the first frame after reset: length-error bit only.
    localparam logic [WORD_W-1:0] FIRST_REPLY = 16'h0400;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic           uv,
        input op_mode_e       mode,
        input logic           len_err,
        input logic           olon,
        input logic           oloff,
        input logic [NCH-1:0] fault
    );
        diag_word_t w;
        w.zero_hi  = 1'b0;
        w.uv       = uv;
        w.zero_mid = 1'b0;
        w.mode     = mode;
        w.len_err  = len_err;
        w.olon     = olon;
        w.oloff    = oloff;
        w.fault    = fault;
        return w;
    endfunction

    function automatic logic oloff_summary(
        input logic [NCH-1:0] cmp,
        input logic [NCH-1:0] on,
        input logic [NCH-1:0] en
    );
        return |(cmp & ~on & en);
    endfunction

    function automatic logic length_legal(
        input logic [MIN_W-1:0]  seen,
        input logic [STEP_W-1:0] phase
    );
        return (seen == MIN_W'(MIN_BITS)) && (phase == '0);
    endfunction

endpackage

// File: rtl/diag_sync.sv
module diag_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d[b]};
                end
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/diag_spi_frame.sv
module diag_spi_frame
    import diag_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] reply,
    output logic              miso,
    output logic              miso_oe,
    output logic              load_pulse,
    output logic              end_pulse,
    output logic              len_ok
);

    logic              cs_d;
    logic              sck_d;
    logic              shift_en;
    logic [WORD_W-1:0] shreg;
    logic [MIN_W-1:0]  seen;
    logic [STEP_W-1:0] phase;

    assign load_pulse = cs_d & ~cs_s;
    assign end_pulse  = ~cs_d & cs_s;
    assign shift_en   = ~cs_s & sck_d & ~sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
            shreg <= '0;
            seen  <= '0;
            phase <= '0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
            if (load_pulse) begin
                shreg <= reply;
                seen  <= '0;
                phase <= '0;
            end else if (shift_en) begin
                shreg <= {shreg[WORD_W-2:0], mosi_s};
                if (seen != MIN_W'(MIN_BITS)) begin
                    seen <= seen + 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

    assign len_ok  = length_legal(seen, phase);
    assign miso    = shreg[WORD_W-1];
    assign miso_oe = ~cs_s;

endmodule

// File: rtl/diag_flags.sv
module diag_flags
    import diag_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_pulse,
    input  logic              end_pulse,
    input  logic              len_ok,
    input  logic              uv_evt,
    input  logic [NCH-1:0]    chan_fault,
    input  logic [1:0]        mode_in,
    input  logic              olon_in,
    input  logic [NCH-1:0]    ol_cmp,
    input  logic [NCH-1:0]    chan_on,
    input  logic [NCH-1:0]    ol_src_en,
    output logic [WORD_W-1:0] reply
);

    logic           uv_q;
    logic [NCH-1:0] fault_q;
    logic           len_err_q;
    logic           first_q;
    logic           snap_uv;
    logic [NCH-1:0] snap_fault;
    logic           diag_sel_q;
    logic           clr;

    // Clear only what a legal frame actually carried out as diagnostics.
    assign clr = end_pulse & len_ok & diag_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            uv_q       <= 1'b1;
            fault_q    <= '0;
            len_err_q  <= 1'b1;
            first_q    <= 1'b1;
            snap_uv    <= 1'b0;
            snap_fault <= '0;
            diag_sel_q <= 1'b0;
        end else begin
            uv_q    <= uv_evt | (uv_q & ~(clr & snap_uv));
            fault_q <= chan_fault | (fault_q & ~({NCH{clr}} & snap_fault));
            if (load_pulse) begin
                snap_uv    <= uv_q;
                snap_fault <= fault_q;
                diag_sel_q <= ~first_q;
            end
            if (end_pulse) begin
                len_err_q <= ~len_ok;
                first_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        if (first_q) begin
            reply = FIRST_REPLY;
        end else begin
            reply = pack_word(uv_q, op_mode_e'(mode_in), len_err_q, olon_in,
                              oloff_summary(ol_cmp, chan_on, ol_src_en), fault_q);
        end
    end

endmodule

// File: rtl/diag_status_spi.sv
module diag_status_spi
    import diag_status_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           sck,
    input  logic           mosi,
    input  logic           uv_evt,
    input  logic [1:0]     mode_in,
    input  logic [NCH-1:0] chan_fault,
    input  logic [NCH-1:0] ol_cmp,
    input  logic [NCH-1:0] chan_on,
    input  logic [NCH-1:0] ol_src_en,
    input  logic           olon_in,
    output logic           miso,
    output logic           miso_oe
);

    logic [2:0]        pins_s;
    logic [WORD_W-1:0] reply_w;
    logic              load_pulse;
    logic              end_pulse;
    logic              len_ok;

    // Order {cs, sck, mosi}; chip select idles high.
    diag_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sck, mosi}),
        .q   (pins_s)
    );

    diag_spi_frame i_frame (
        .clk        (clk),
        .rst        (rst),
        .cs_s       (pins_s[2]),
        .sck_s      (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .reply      (reply_w),
        .miso       (miso),
        .miso_oe    (miso_oe),
        .load_pulse (load_pulse),
        .end_pulse  (end_pulse),
        .len_ok     (len_ok)
    );

    diag_flags i_flags (
        .clk        (clk),
        .rst        (rst),
        .load_pulse (load_pulse),
        .end_pulse  (end_pulse),
        .len_ok     (len_ok),
        .uv_evt     (uv_evt),
        .chan_fault (chan_fault),
        .mode_in    (mode_in),
        .olon_in    (olon_in),
        .ol_cmp     (ol_cmp),
        .chan_on    (chan_on),
        .ol_src_en  (ol_src_en),
        .reply      (reply_w)
    );

endmodule

// File: rtl/diag_status_spi_chk.sv
module diag_status_spi_chk
    import diag_status_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              miso_oe,
    input logic              uv_evt,
    input logic [NCH-1:0]    chan_fault,
    input logic              load_pulse,
    input logic              end_pulse,
    input logic              len_ok,
    input logic [WORD_W-1:0] reply
);

    logic seen_load;
    logic seen_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_load <= 1'b0;
            seen_end  <= 1'b0;
        end else begin
            if (load_pulse) seen_load <= 1'b1;
            if (end_pulse)  seen_end  <= 1'b1;
        end
    end

    p_oe_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso_oe);

    p_first_reply_r4: assert property (@(posedge clk) disable iff (rst)
        (load_pulse && !seen_load) |-> (reply == FIRST_REPLY));

    p_uv_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (seen_end && uv_evt) |=> reply[14]);

    p_fault_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (seen_end && (|chan_fault)) |=>
            ((reply[NCH-1:0] & $past(chan_fault)) == $past(chan_fault)));

    p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (seen_end && !end_pulse) |=>
            ((($past(reply[14]) & ~reply[14]) == 1'b0) &&
             (($past(reply[NCH-1:0]) & ~reply[NCH-1:0]) == '0)));

    p_len_err_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (seen_end && !end_pulse) |=> $stable(reply[10]));

    p_bad_len_keeps_r13: assert property (@(posedge clk) disable iff (rst)
        (seen_end && end_pulse && !len_ok) |=>
            (($past(reply[NCH-1:0]) & ~reply[NCH-1:0]) == '0));

endmodule

bind diag_status_spi diag_status_spi_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .miso_oe    (miso_oe),
    .uv_evt     (uv_evt),
    .chan_fault (chan_fault),
    .load_pulse (load_pulse),
    .end_pulse  (end_pulse),
    .len_ok     (len_ok),
    .reply      (reply_w)
);

// File: tb/test_diag_status_spi.sv
`timescale 1ns/1ps
module test_diag_status_spi;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       uv_evt = 1'b0;
    logic [1:0] mode = 2'b11;
    logic [7:0] fault = 8'h00;
    logic [7:0] cmp = 8'h00;
    logic [7:0] on = 8'h00;
    logic [7:0] en = 8'h00;
    logic       olon = 1'b0;
    wire        miso;
    wire        miso_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the sticky state
    logic       m_uv = 1'b1;
    logic       m_ter = 1'b1;
    logic       m_first = 1'b1;
    logic [7:0] m_err = 8'h00;

    localparam int HALF = 6;
    localparam logic [31:0] TXPAT = 32'hA5C3_3C5A;

    // {nbits[41:36], uv[35], fault[34:27], mode[26:25], olon[24], cmp[23:16], on[15:8], en[7:0]}
    localparam int NV = 8;
    localparam logic [41:0] VEC [NV] = '{
        {6'd16, 1'b0, 8'h00, 2'b11, 1'b0, 8'h00, 8'h00, 8'h00},
        {6'd16, 1'b0, 8'h00, 2'b11, 1'b0, 8'h00, 8'h00, 8'h00},
        {6'd16, 1'b0, 8'h05, 2'b10, 1'b1, 8'hff, 8'h0f, 8'hf0},
        {6'd13, 1'b0, 8'h80, 2'b10, 1'b0, 8'h00, 8'h00, 8'h00},
        {6'd24, 1'b0, 8'h00, 2'b10, 1'b0, 8'h0f, 8'h0f, 8'hff},
        {6'd32, 1'b1, 8'h00, 2'b01, 1'b0, 8'h01, 8'h00, 8'h00},
        {6'd20, 1'b0, 8'h00, 2'b11, 1'b0, 8'h00, 8'h00, 8'h00},
        {6'd16, 1'b0, 8'h00, 2'b11, 1'b0, 8'h00, 8'h00, 8'h00}
    };

    diag_status_spi i_diag_status_spi (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .uv_evt     (uv_evt),
        .mode_in    (mode),
        .chan_fault (fault),
        .ol_cmp     (cmp),
        .chan_on    (on),
        .ol_src_en  (en),
        .olon_in    (olon),
        .miso       (miso),
        .miso_oe    (miso_oe)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_frame(input int nbits, input logic [7:0] mid_fault, input bit uv_end,
                             output logic [31:0] rx, output logic oe_seen);
        rx = '0;
        oe_seen = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck  = 1'b1;
            mosi = TXPAT[31-i];
            repeat (HALF) @(negedge clk);
            rx[31-i] = miso;
            if (i == 0) oe_seen = miso_oe;
            if (i == 4 && mid_fault != 8'h00) begin
                fault = mid_fault;
                @(negedge clk) fault = 8'h00;
            end
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        if (uv_end) begin
            // release at edge k; clear lands at posedge k+3
            @(negedge clk);
            @(negedge clk) uv_evt = 1'b1;
            @(negedge clk) uv_evt = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic run_check(input int nbits, input logic [7:0] mid_fault, input bit uv_end,
                             input string tag, output logic [15:0] got);
        logic [31:0] rx;
        logic        oe;
        logic [15:0] exp;
        logic [15:0] mask;
        logic [31:0] echo_a;
        logic [31:0] echo_e;
        bit          legal;
        exp = m_first ? 16'h0400
                      : {1'b0, m_uv, 1'b0, mode, m_ter, olon, |(cmp & ~on & en), m_err};
        spi_frame(nbits, mid_fault, uv_end, rx, oe);
        mask = (nbits >= 16) ? 16'hffff : ~(16'hffff >> nbits);
        chk((rx[31:16] & mask) == (exp & mask), tag, {16'h0, rx[31:16] & mask}, {16'h0, exp & mask});
        chk(oe == 1'b1, "R12 oe during frame", {31'h0, oe}, 32'h1);
        if (nbits > 16) begin
            echo_a = '0;
            echo_e = '0;
            for (int i = 16; i < nbits; i++) begin
                echo_a[i] = rx[31-i];
                echo_e[i] = TXPAT[47-i];
            end
            chk(echo_a == echo_e, "R11 mosi echo after 16 bits", echo_a, echo_e);
        end
        legal = (nbits >= 16) && ((nbits - 16) % 8 == 0);
        if (legal && !m_first) begin
            m_uv  = 1'b0;
            m_err = 8'h00;
        end
        m_err   = m_err | mid_fault;
        if (uv_end) m_uv = 1'b1;
        m_ter   = !legal;
        m_first = 1'b0;
        got = rx[31:16];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(miso_oe == 1'b0, "R12 idle after reset", {31'h0, miso_oe}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mode = VEC[v][26:25];
            olon = VEC[v][24];
            cmp  = VEC[v][23:16];
            on   = VEC[v][15:8];
            en   = VEC[v][7:0];
            if (VEC[v][35]) begin
                uv_evt = 1'b1;
                @(negedge clk) uv_evt = 1'b0;
                m_uv = 1'b1;
            end
            if (VEC[v][34:27] != 8'h00) begin
                fault = VEC[v][34:27];
                @(negedge clk) fault = 8'h00;
                m_err = m_err | VEC[v][34:27];
            end
            repeat (3) @(negedge clk);
            // R2 R3 R4 R5 R6 R7 R8 R11 R13 via the model
            run_check(int'(VEC[v][41:36]), 8'h00, 1'b0, "R2 R3 R4 R5 R6 R7 R8 R13 word", got);
            if (v == 0) chk(got == 16'h0400, "R4 first reply", {16'h0, got}, 32'h0400);
            if (v == 1) chk(got == 16'h5800, "R1 reset word", {16'h0, got}, 32'h5800);
        end

        // R10: event during a frame whose word showed the flag as 0
        mode = 2'b11; olon = 1'b0; cmp = 8'h00; on = 8'h00; en = 8'h00;
        run_check(16, 8'h08, 1'b0, "R10 frame with mid event", got);
        run_check(16, 8'h00, 1'b0, "R10 mid event survives", got);
        chk(got[3] == 1'b1, "R10 fault bit 3 kept", {31'h0, got[3]}, 32'h1);

        // R9: event in the clear cycle wins
        @(negedge clk) uv_evt = 1'b1;
        @(negedge clk) uv_evt = 1'b0;
        m_uv = 1'b1;
        repeat (3) @(negedge clk);
        run_check(16, 8'h00, 1'b1, "R9 frame with clear-cycle event", got);
        run_check(16, 8'h00, 1'b0, "R9 uv kept", got);
        chk(got[14] == 1'b1, "R9 uv bit after collision", {31'h0, got[14]}, 32'h1);
        run_check(16, 8'h00, 1'b0, "R5 uv cleared after read", got);
        chk(got[14] == 1'b0, "R5 uv bit", {31'h0, got[14]}, 32'h0);

        chk(miso_oe == 1'b0, "R12 idle between frames", {31'h0, miso_oe}, 32'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule